// File: doc/BRIEF.md
# Burst Read Initial-Latency Controller

This block times the read side of a synchronous burst memory interface. A configuration write stores a 3-bit latency code that the host places on address bits 14:12. Each burst then waits a number of clock edges before its first data word. That number comes from the stored code, plus a penalty for an odd start address, plus a penalty for a linear burst that starts close enough to a 64-word block edge to straddle it.

While the burst waits, a ready flag tells the host when data is due. Once data flows, a word pointer walks through a small internal word array. The pointer moves either linearly without limit or through a fixed run of 8, 16 or 32 words that stays inside its aligned 64-word block. Dropping the enable input cancels the burst at once and leaves the latency setting untouched.

Top module: `burst_latency_ctrl`

## Requirements
- R1: While `cfg_we` is high at a clock edge, `addr[14:12]` is stored as the latency code, in any controller state. The code sets the base latency: 000→2, 001→3, 010→4, 011→5, 100→6, 101→7 cycles, and 110 or 111→7 cycles.
- R2: After `rst_n` is asserted low, the stored code is 101, giving a base latency of 7.
- R3: A burst starts at a clock edge where `en` and `start` are both high. The pointer loads `addr`. Count the edge that samples `start` as edge 1. `dvalid` first goes high after edge L, where L is the total latency, and the first word comes from the start address.
- R4: With code 000, `rdy` rises in the same cycle as `dvalid`. In every mode, `rdy` is high whenever `dvalid` is high.
- R5: With any code other than 000, `rdy` rises one cycle before `dvalid`.
- R6: If `addr[0]` is 1 at the start, L is one cycle longer than the base latency.
- R7: A linear burst (`mode`=00) whose start offset `addr[5:2]` is 1111 (words 3Ch–3Fh of a block) adds one more cycle. This penalty adds to the odd-address penalty. Fixed bursts never take it.
- R8: `mode` 01, 10 and 11 select fixed bursts of 8, 16 and 32 words. On each data cycle after the first, only `ptr[5:0]` increments, wrapping from 3Fh to 00h, and the upper bits do not change. `dvalid` stays high for exactly that many cycles, and then the controller goes idle.
- R9: In linear mode (`mode`=00), `ptr` increments by one across its full width on every data cycle after the first, including across 64-word boundaries. This continues until `en` falls.
- R10: When `en` is low, `rdy` and `dvalid` are low in that same cycle and the controller goes idle. `start` is ignored while `en` is low. The latency code keeps its value.
- R11: `dout` is the array word at `ptr`. Word i holds i XOR A5C3h, where i is the low 8 bits of `ptr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Device enable; low cancels any burst |
| cfg_we | input | 1 | Configuration write strobe |
| start | input | 1 | Burst start request |
| addr | input | AW | Start word address; bits 14:12 carry the code during configuration |
| mode | input | 2 | Burst kind: 00 linear, 01/10/11 fixed 8/16/32 words |
| rdy | output | 1 | Ready/wait indication to the host |
| dvalid | output | 1 | Data word on `dout` is valid |
| ptr | output | AW | Current word pointer |
| dout | output | DW | Word read from the internal array |

## Verification
A wrong stored code or a wrong latency count shows up as `dvalid` rising on the wrong edge of the very first burst, so every code is measured edge by edge. A wrong penalty decision moves the first word by exactly one cycle, and a premature or late `rdy` is visible one cycle before the data. A pointer that leaves its 64-word block, or stops one word short, shows up in `ptr` and `dout` on the first data cycle after the wrap.

// File: rtl/burst_latency_ctrl.sv
module burst_latency_ctrl #(
  parameter int          AW    = 16,
  parameter int          DW    = 16,
  parameter int          DEPTH = 256,
  parameter logic [15:0] SEED  = 16'hA5C3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cfg_we,
  input  logic          start,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    mode,
  output logic          rdy,
  output logic          dvalid,
  output logic [AW-1:0] ptr,
  output logic [DW-1:0] dout
);
  localparam int IW = $clog2(DEPTH);

  typedef enum logic [1:0] {IDLE, WAIT, DATA} st_t;

  st_t        st;
  logic [2:0] code_q;
  logic [1:0] mode_q;
  logic       early_q;
  logic [3:0] cnt, tot_q, base, tot_d;
  logic [5:0] beat, last_beat;
  logic       bnd;
  logic [DW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_mem
    assign mem[g] = DW'(g) ^ DW'(SEED);
  end

  assign base      = (code_q >= 3'd5) ? 4'd7 : {1'b0, code_q} + 4'd2;
  assign bnd       = (mode == 2'd0) && (&addr[5:2]);
  assign tot_d     = base + {3'b0, addr[0]} + {3'b0, bnd};
  assign last_beat = (mode_q == 2'd1) ? 6'd7 : (mode_q == 2'd2) ? 6'd15 : 6'd31;

  assign dvalid = en && (st == DATA);
  assign rdy    = en && ((st == DATA) || (st == WAIT && early_q && cnt == tot_q - 4'd1));
  assign dout   = mem[ptr[IW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= 3'd5;
      st      <= IDLE;
      mode_q  <= 2'd0;
      early_q <= 1'b1;
      cnt     <= 4'd0;
      tot_q   <= 4'd7;
      beat    <= 6'd0;
      ptr     <= '0;
    end else begin
      if (cfg_we) code_q <= addr[14:12];
      if (!en) begin
        st <= IDLE;
      end else if (start) begin
        st      <= WAIT;
        cnt     <= 4'd1;
        tot_q   <= tot_d;
        ptr     <= addr;
        mode_q  <= mode;
        early_q <= (code_q != 3'd0);
      end else begin
        case (st)
          WAIT: begin
            cnt <= cnt + 4'd1;
            if (cnt == tot_q - 4'd1) begin
              st   <= DATA;
              beat <= 6'd0;
            end
          end
          DATA: begin
            if (mode_q != 2'd0 && beat == last_beat) begin
              st <= IDLE;
            end else begin
              beat <= beat + 6'd1;
              ptr  <= (mode_q == 2'd0) ? ptr + 1'b1 : {ptr[AW-1:6], ptr[5:0] + 6'd1};
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/burst_latency_chk.sv
module burst_latency_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          rdy,
  input logic          dvalid,
  input logic [AW-1:0] ptr,
  input logic [1:0]    mode_q,
  input logic          early_q,
  input logic [2:0]    code_q
);
  p_reset_code_r2: assert property (@(posedge clk) !rst_n |=> code_q == 3'd5)
    else $error("reset did not restore latency code");

  p_rdy_with_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dvalid |-> rdy)
    else $error("data valid without ready");

  p_rdy_same_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dvalid) && !early_q |-> !$past(rdy))
    else $error("ready early at two-cycle setting");

  p_rdy_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dvalid) && early_q |-> $past(rdy))
    else $error("ready did not lead data");

  p_wrap_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dvalid && $past(dvalid) && mode_q != 2'd0 |-> ptr[AW-1:6] == $past(ptr[AW-1:6]))
    else $error("fixed burst left its block");

  p_lin_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dvalid && $past(dvalid) && mode_q == 2'd0 |-> ptr == $past(ptr) + 1'b1)
    else $error("linear pointer step wrong");

  p_en_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en) |-> !dvalid)
    else $error("data after enable dropped");
endmodule

bind burst_latency_ctrl burst_latency_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .rdy(rdy), .dvalid(dvalid),
  .ptr(ptr), .mode_q(mode_q), .early_q(early_q), .code_q(code_q)
);

// File: tb/sim_burst_latency_ctrl.sv
module sim_burst_latency_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1;
  logic        cfg_we = 1'b0;
  logic        start = 1'b0;
  logic [15:0] addr = '0;
  logic [1:0]  mode = '0;
  logic        rdy, dvalid;
  logic [15:0] ptr, dout;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  burst_latency_ctrl u0 (.clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we), .start(start),
    .addr(addr), .mode(mode), .rdy(rdy), .dvalid(dvalid), .ptr(ptr), .dout(dout));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg(input int code);
    @(negedge clk); cfg_we = 1'b1; addr = {1'b0, 3'(code), 12'h0};
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic burst(input string req, input int code, input logic [15:0] a,
                       input logic [1:0] m, input int nchk);
    int tot, kr, kd, n;
    logic [15:0] exp;
    tot = ((code >= 5) ? 7 : code + 2) + int'(a[0]) + ((m == 2'd0 && a[5:2] == 4'hF) ? 1 : 0);
    @(negedge clk); addr = a; mode = m; start = 1'b1;
    kr = 0; kd = 0;
    for (int k = 1; k <= 14 && kd == 0; k++) begin
      @(negedge clk); start = 1'b0;
      if (rdy && kr == 0) kr = k;
      if (dvalid) kd = k;
    end
    check({req, " R3 latency"}, kd, tot);
    check((code == 0) ? "R4 ready with data" : "R5 ready lead", kr, (code == 0) ? tot : tot - 1);
    n = (m == 2'd1) ? 8 : (m == 2'd2) ? 16 : (m == 2'd3) ? 32 : nchk;
    for (int i = 0; i < n; i++) begin
      exp = (m == 2'd0) ? 16'(a + 16'(i)) : {a[15:6], 6'(a[5:0] + 6'(i))};
      check((m == 2'd0) ? "R9 pointer" : "R8 pointer", ptr, exp);
      check("R11 data", dout, {8'h0, exp[7:0]} ^ 16'hA5C3);
      check("R4 ready held", {31'b0, rdy & dvalid}, 1);
      @(negedge clk);
    end
    if (m != 2'd0) begin
      check("R8 burst end", {31'b0, dvalid}, 0);
    end else begin
      en = 1'b0; #1;
      check("R10 cancel", {30'b0, rdy, dvalid}, 0);
      @(negedge clk); en = 1'b1;
    end
  endtask

  task automatic t_reset;
    #1;
    check("R10 reset outputs", {30'b0, rdy, dvalid}, 0);
    @(negedge clk); rst_n = 1'b1;
    burst("R2 default", 5, 16'h0040, 2'd1, 8);
  endtask

  task automatic t_codes;
    for (int c = 0; c < 8; c++) begin
      cfg(c);
      burst("R1 code", c, 16'h0100, 2'd1, 8);
    end
  endtask

  task automatic t_odd;
    cfg(2); burst("R6 odd", 2, 16'h0105, 2'd2, 16);
    cfg(0); burst("R6 odd code0", 0, 16'h0001, 2'd1, 8);
  endtask

  task automatic t_boundary;
    cfg(1);
    burst("R7 even boundary", 1, 16'h003C, 2'd0, 8);
    burst("R7 odd boundary", 1, 16'h003F, 2'd0, 4);
    burst("R7 no boundary", 1, 16'h0010, 2'd0, 3);
    burst("R7 fixed no penalty", 1, 16'h003C, 2'd1, 8);
  endtask

  task automatic t_wrap;
    cfg(3);
    burst("R8 wrap8", 3, 16'h013C, 2'd1, 8);
    burst("R8 wrap16", 3, 16'h0037, 2'd2, 16);
    burst("R8 wrap32", 3, 16'h002A, 2'd3, 32);
  endtask

  task automatic t_en_drop;
    cfg(4);
    @(negedge clk); addr = 16'h0200; mode = 2'd3; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); @(negedge clk);
    en = 1'b0; #1;
    check("R10 drop in wait", {30'b0, rdy, dvalid}, 0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check("R10 start ignored", {30'b0, rdy, dvalid}, 0);
    end
    en = 1'b1;
    burst("R10 code kept", 4, 16'h0200, 2'd1, 8);
  endtask

  task automatic t_hw_reset;
    cfg(0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    burst("R2 after reset", 5, 16'h0000, 2'd1, 8);
  endtask

  initial begin
    t_reset();
    t_codes();
    t_odd();
    t_boundary();
    t_wrap();
    t_en_drop();
    t_hw_reset();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule